// File: doc/BRIEF.md
# Performance Monitor Counter Bank

A bank of ten 48-bit event counters for a processor core, controlled through a simple word-wide register port. Counter 0 tallies clock cycles and counter 1 tallies retired instructions. Counters 2 to 9 are general purpose: each follows an 8-bit event code that selects one line of an event pulse vector. Every counter has its own count enable, overflow-interrupt enable and a pair of privilege filters (user, kernel). A privilege input marks each cycle as user or kernel, and a counter advances only if the filter for the current level is set.

When a counter's bit 47 goes from 0 to 1 by counting, its bit in an overflow status register is set. Software clears a status bit by writing a one to it. The interrupt output is raised while the interrupt mode is active and some counter has both a status bit and an interrupt enable set. An interrupt-active flag records this one cycle later and stays set until software writes control word 0. Software can load any counter directly, and reads return data one cycle after the request.

Register map, one 64-bit word per address: 0 to 9 are the counters (zero-extended), 10 is control word 0, 11 is control word 1, 12 and 13 are the two event-select words, and 14 is the overflow status.

Top module: `pmc_bank`

## Requirements
- R1: After synchronous reset every counter, both control words, both select words and the status word read zero, and `irq_o` is low.
- R2: A read request at one rising edge returns the addressed word on `rdata` with `rvalid` high after that edge, which is one cycle of latency. The word shows the state before any update made at that same edge. A written select word reads back unchanged.
- R3: Counter 0 adds one on each enabled cycle and counter 1 adds one for each cycle with `instr_i` high. The select words have no effect on either counter.
- R4: Counter k, for k from 2 to 5, takes its event code from bits [8(k-2)+7 : 8(k-2)] of select word 0. Counter k, for k from 6 to 9, takes its code from bits [8(k-6)+7 : 8(k-6)] of select word 1. Code c counts the cycles in which `evt_i[c]` is high. A code at or above the number of event lines counts nothing.
- R5: Control word 0 holds the count enables for counters 0-7 in bits [7:0] and for counters 8-9 in bits [33:32]. A counter whose enable is clear holds its value.
- R6: Control word 1 holds the user filters for counters 0-7 in bits [7:0] and for 8-9 in bits [33:32], and the kernel filters for 0-7 in bits [15:8] and for 8-9 in bits [41:40]. A counter advances only if the filter for the current `priv_i` (0 user, 1 kernel) is set.
- R7: Writing a counter address loads the low 48 bits of `wdata`. In the same cycle a load takes priority over counting.
- R8: A status bit is set only when counting moves the counter's bit 47 from 0 to 1. Wrapping past 48 bits does not set it, and neither does a direct load.
- R9: Writing the status word clears each bit written as one and leaves the bits written as zero. A new overflow in the same cycle wins over the clear.
- R10: Control word 0 has the interrupt-mode field in bits [10:8] (0 off, 1 active) and the interrupt enables in bits [19:12] for counters 0-7 and [45:44] for 8-9. `irq_o` is high exactly when the mode is active and some counter has both its status bit and its interrupt enable set. The active flag, bit 11, sets one cycle after `irq_o` is high.
- R11: Any write to control word 0 clears the active flag. Writing one to bit 11 never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 1 | Privilege of the current cycle: 0 user, 1 kernel |
| instr_i | input | 1 | One instruction retired this cycle |
| evt_i | input | NUM_EVT | Event pulses, indexed by event code |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read request |
| addr | input | 4 | Word address |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Writes, counting and status changes all take effect at the rising edge where the strobe or pulse is present. `irq_o` follows from registered state and so changes at that same edge, while the active flag shows up one edge later. Read data belongs to the edge after the request and reflects the state before that edge's update. The bench drives inputs on falling edges and samples on the next falling edge. It adds an idle cycle before reading the active flag, and it stops counting with a control write before reading any counter, so every count it expects equals the number of edges in its window.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int NUM_CTR = 10;
    localparam int CW      = 48;
    localparam int DW      = 64;
    localparam int AW      = 4;
    localparam int EVW     = 8;

    localparam int ADR_CTL0 = NUM_CTR;
    localparam int ADR_CTL1 = NUM_CTR + 1;
    localparam int ADR_SEL0 = NUM_CTR + 2;
    localparam int ADR_SEL1 = NUM_CTR + 3;
    localparam int ADR_STAT = NUM_CTR + 4;

    // control word 0 layout
    localparam int C0_EN_LO    = 0;
    localparam int C0_MODE_LSB = 8;
    localparam int MODE_W      = 3;
    localparam int C0_ACT      = 11;
    localparam int C0_IEN_LO   = 12;
    localparam int C0_EN_HI    = 32;
    localparam int C0_IEN_HI   = 44;
    // control word 1 layout
    localparam int C1_USR_LO = 0;
    localparam int C1_KRN_LO = 8;
    localparam int C1_USR_HI = 32;
    localparam int C1_KRN_HI = 40;

    typedef enum logic [MODE_W-1:0] {
        IMODE_OFF    = 3'd0,
        IMODE_ACTIVE = 3'd1
    } imode_e;

    typedef struct packed {
        logic cnt_en;
        logic usr;
        logic krn;
    } ctr_cfg_t;

    // bit position of counter idx inside a field split into 0-7 and 8-9 groups
    function automatic int grp_pos(input int idx, input int lo, input int hi);
        return (idx < 8) ? (lo + idx) : (hi + idx - 8);
    endfunction
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter
    import pmc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ctr_cfg_t      cfg,
    input  logic          priv,
    input  logic          src,
    input  logic          wr,
    input  logic [CW-1:0] wval,
    output logic [CW-1:0] cnt,
    output logic          ovf
);
    logic          priv_ok;
    logic          step;
    logic [CW-1:0] nxt;

    assign priv_ok = priv ? cfg.krn : cfg.usr;
    assign step    = cfg.cnt_en && priv_ok && src;
    assign nxt     = cnt + CW'(1);
    assign ovf     = step && !wr && !cnt[CW-1] && nxt[CW-1];

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (wr)   cnt <= wval;
        else if (step) cnt <= nxt;
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!wr && !step) |=> $stable(cnt)); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cnt == $past(wval))); // R7
    AST_OVF_TOP: assert property (@(posedge clk) disable iff (rst)
        ovf |=> cnt[CW-1]); // R8
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
    import pmc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic [NUM_CTR-1:0]      ovf_set,
    output ctr_cfg_t [NUM_CTR-1:0]  cfg,
    output logic [NUM_CTR-1:0]      status,
    output logic                    irq,
    output logic [DW-1:0]           ctl0_q,
    output logic [DW-1:0]           ctl1_q,
    output logic [DW-1:0]           sel0_q,
    output logic [DW-1:0]           sel1_q
);
    logic [NUM_CTR-1:0] en_r, ien_r, usr_r, krn_r;
    logic [MODE_W-1:0]  mode_r;
    logic               act_r;
    logic               we_c0, we_c1, we_s0, we_s1, we_st;
    logic [NUM_CTR-1:0] clr_mask;

    assign we_c0 = we && (addr == AW'(ADR_CTL0));
    assign we_c1 = we && (addr == AW'(ADR_CTL1));
    assign we_s0 = we && (addr == AW'(ADR_SEL0));
    assign we_s1 = we && (addr == AW'(ADR_SEL1));
    assign we_st = we && (addr == AW'(ADR_STAT));
    assign clr_mask = we_st ? wdata[NUM_CTR-1:0] : '0;

    assign irq = (mode_r == IMODE_ACTIVE) && |(status & ien_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_r   <= '0;
            ien_r  <= '0;
            usr_r  <= '0;
            krn_r  <= '0;
            mode_r <= IMODE_OFF;
            act_r  <= 1'b0;
            sel0_q <= '0;
            sel1_q <= '0;
            status <= '0;
        end else begin
            if (we_c0) begin
                for (int i = 0; i < NUM_CTR; i++) begin
                    en_r[i]  <= wdata[grp_pos(i, C0_EN_LO, C0_EN_HI)];
                    ien_r[i] <= wdata[grp_pos(i, C0_IEN_LO, C0_IEN_HI)];
                end
                mode_r <= wdata[C0_MODE_LSB +: MODE_W];
            end
            if (we_c1) begin
                for (int i = 0; i < NUM_CTR; i++) begin
                    usr_r[i] <= wdata[grp_pos(i, C1_USR_LO, C1_USR_HI)];
                    krn_r[i] <= wdata[grp_pos(i, C1_KRN_LO, C1_KRN_HI)];
                end
            end
            if (we_s0) sel0_q <= wdata;
            if (we_s1) sel1_q <= wdata;
            status <= (status & ~clr_mask) | ovf_set;
            if (we_c0)    act_r <= 1'b0;
            else if (irq) act_r <= 1'b1;
        end
    end

    always_comb begin
        ctl0_q = '0;
        ctl1_q = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            ctl0_q[grp_pos(i, C0_EN_LO, C0_EN_HI)]   = en_r[i];
            ctl0_q[grp_pos(i, C0_IEN_LO, C0_IEN_HI)] = ien_r[i];
            ctl1_q[grp_pos(i, C1_USR_LO, C1_USR_HI)] = usr_r[i];
            ctl1_q[grp_pos(i, C1_KRN_LO, C1_KRN_HI)] = krn_r[i];
            cfg[i].cnt_en = en_r[i];
            cfg[i].usr    = usr_r[i];
            cfg[i].krn    = krn_r[i];
        end
        ctl0_q[C0_MODE_LSB +: MODE_W] = mode_r;
        ctl0_q[C0_ACT] = act_r;
    end

    AST_STAT_W1C: assert property (@(posedge clk) disable iff (rst)
        (we_st && |(wdata[NUM_CTR-1:0] & ~ovf_set))
        |=> ((status & $past(wdata[NUM_CTR-1:0] & ~ovf_set)) == '0)); // R9
    AST_ACT_SET: assert property (@(posedge clk) disable iff (rst)
        (irq && !we_c0) |=> act_r); // R10
    AST_ACT_CLR: assert property (@(posedge clk) disable iff (rst)
        we_c0 |=> !act_r); // R11
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               priv_i,
    input  logic               instr_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [3:0]         addr,
    input  logic [63:0]        wdata,
    output logic [63:0]        rdata,
    output logic               rvalid,
    output logic               irq_o
);
    localparam int EIW = $clog2(NUM_EVT);
    localparam logic [EVW:0] EVT_LIM = (EVW+1)'(NUM_EVT);

    ctr_cfg_t [NUM_CTR-1:0] cfg;
    logic [NUM_CTR-1:0]     status, ovf, src;
    logic [DW-1:0]          ctl0_q, ctl1_q, sel0_q, sel1_q, rd_word;
    logic [CW-1:0]          cnt_a [NUM_CTR];

    pmc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .we(wr_en), .addr(addr), .wdata(wdata),
        .ovf_set(ovf), .cfg(cfg), .status(status), .irq(irq_o),
        .ctl0_q(ctl0_q), .ctl1_q(ctl1_q), .sel0_q(sel0_q), .sel1_q(sel1_q)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        if (g == 0) begin : g_cyc
            assign src[g] = 1'b1;
        end else if (g == 1) begin : g_ins
            assign src[g] = instr_i;
        end else begin : g_evt
            logic [EVW-1:0] code;
            if (g < 6) begin : g_lo
                assign code = sel0_q[(g-2)*EVW +: EVW];
            end else begin : g_hi
                assign code = sel1_q[(g-6)*EVW +: EVW];
            end
            assign src[g] = ({1'b0, code} < EVT_LIM) && evt_i[code[EIW-1:0]];
        end

        pmc_counter u_cnt (
            .clk(clk), .rst(rst), .cfg(cfg[g]), .priv(priv_i), .src(src[g]),
            .wr(wr_en && (addr == AW'(g))), .wval(wdata[CW-1:0]),
            .cnt(cnt_a[g]), .ovf(ovf[g])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CTR; i++)
            if (addr == AW'(i)) rd_word = DW'(cnt_a[i]);
        if (addr == AW'(ADR_CTL0)) rd_word = ctl0_q;
        if (addr == AW'(ADR_CTL1)) rd_word = ctl1_q;
        if (addr == AW'(ADR_SEL0)) rd_word = sel0_q;
        if (addr == AW'(ADR_SEL1)) rd_word = sel1_q;
        if (addr == AW'(ADR_STAT)) rd_word = DW'(status);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_word;
        end
    end

    AST_RD_LAT: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid); // R2
endmodule

// File: tb/sim_pmc_bank.sv
`timescale 1ns/1ps
module sim_pmc_bank;
    logic        clk = 0;
    logic        rst = 1;
    logic        priv_i = 0, instr_i = 0, wr_en = 0, rd_en = 0;
    logic [15:0] evt_i = '0;
    logic [3:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        rvalid, irq_o;
    logic        last_rv;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    pmc_bank #(.NUM_EVT(16)) u0 (
        .clk(clk), .rst(rst), .priv_i(priv_i), .instr_i(instr_i), .evt_i(evt_i),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .irq_o(irq_o)
    );

    function automatic logic [63:0] c0(input logic [9:0] en, input logic [9:0] ien,
                                       input logic [2:0] mode);
        logic [63:0] w = '0;
        w[7:0] = en[7:0];   w[33:32] = en[9:8];
        w[19:12] = ien[7:0]; w[45:44] = ien[9:8];
        w[10:8] = mode;
        return w;
    endfunction

    function automatic logic [63:0] c1(input logic [9:0] usr, input logic [9:0] krn);
        logic [63:0] w = '0;
        w[7:0] = usr[7:0];  w[33:32] = usr[9:8];
        w[15:8] = krn[7:0]; w[41:40] = krn[9:8];
        return w;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0; d = rdata; last_rv = rvalid;
    endtask

    task automatic pulse(input logic [15:0] v, input int n);
        evt_i = v;
        repeat (n) @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd(4'd10, d); chk("R1 ctl0", d, 0);
        rd(4'd11, d); chk("R1 ctl1", d, 0);
        rd(4'd14, d); chk("R1 status", d, 0);
        rd(4'd0, d);  chk("R1 cnt0", d, 0);
        chk("R1 irq", irq_o, 0);
    endtask

    task automatic t_map;
        logic [63:0] d;
        wr(4'd12, 64'h1122334455667788);
        rd(4'd12, d); chk("R2 sel0 readback", d, 64'h1122334455667788);
        chk("R2 rvalid", last_rv, 1);
        wr(4'd5, 64'hFFFF_1234_5678_9ABC);
        rd(4'd5, d); chk("R7 counter load low 48 bits", d, 64'h1234_5678_9ABC);
    endtask

    task automatic t_fixed;
        logic [63:0] d;
        wr(4'd11, c1(10'h3FF, 10'h000));
        wr(4'd0, 0);
        wr(4'd10, c0(10'h001, 0, 0));
        repeat (5) @(negedge clk);
        wr(4'd10, 0);
        rd(4'd0, d); chk("R3 cycle counter", d, 6);
        wr(4'd1, 0);
        wr(4'd10, c0(10'h002, 0, 0));
        instr_i = 1; repeat (4) @(negedge clk); instr_i = 0;
        @(negedge clk);
        wr(4'd10, 0);
        rd(4'd1, d); chk("R3 instruction counter", d, 4);
        rd(4'd0, d); chk("R5 disabled counter holds", d, 6);
    endtask

    task automatic t_select;
        logic [63:0] d;
        wr(4'd12, 64'h00FF_0500);
        wr(4'd13, 64'h0200_0000);
        wr(4'd10, c0(10'h21C, 0, 0));
        pulse(16'h0020, 3);
        pulse(16'h0004, 4);
        pulse(16'hFFFF, 2);
        wr(4'd10, 0);
        rd(4'd2, d); chk("R4 cnt2 code 0", d, 2);
        rd(4'd3, d); chk("R4 cnt3 code 5", d, 5);
        rd(4'd9, d); chk("R4 cnt9 code 2 from sel1", d, 6);
        rd(4'd4, d); chk("R4 cnt4 code out of range", d, 0);
    endtask

    task automatic t_hi_group;
        logic [63:0] d;
        wr(4'd13, 64'h0207_0000);
        wr(4'd10, c0(10'h100, 0, 0));
        pulse(16'h0080, 3);
        wr(4'd10, c0(10'h0FF, 0, 0));
        pulse(16'h0080, 2);
        wr(4'd10, 0);
        rd(4'd8, d); chk("R5 high enable group", d, 3);
    endtask

    task automatic t_priv;
        logic [63:0] d;
        wr(4'd11, c1(10'h008, 10'h000));
        wr(4'd10, c0(10'h008, 0, 0));
        priv_i = 1; pulse(16'h0020, 2);
        priv_i = 0; pulse(16'h0020, 3);
        wr(4'd10, 0);
        rd(4'd3, d); chk("R6 user filter", d, 8);
        wr(4'd11, c1(10'h000, 10'h008));
        wr(4'd10, c0(10'h008, 0, 0));
        priv_i = 1; pulse(16'h0020, 1);
        priv_i = 0; pulse(16'h0020, 2);
        wr(4'd10, 0);
        rd(4'd3, d); chk("R6 kernel filter", d, 9);
        wr(4'd11, c1(10'h3FF, 10'h000));
    endtask

    task automatic t_write_wins;
        logic [63:0] d;
        wr(4'd10, c0(10'h001, 0, 0));
        wr(4'd0, 100);
        wr(4'd10, 0);
        rd(4'd0, d); chk("R7 load beats count", d, 101);
    endtask

    task automatic t_ovf;
        logic [63:0] d;
        wr(4'd2, 64'h7FFF_FFFF_FFFF);
        wr(4'd10, c0(10'h004, 0, 0));
        pulse(16'h0001, 1);
        wr(4'd10, 0);
        rd(4'd2, d);  chk("R8 cross bit 47", d, 64'h8000_0000_0000);
        rd(4'd14, d); chk("R8 status set", d, 64'h004);
        wr(4'd14, 0);
        rd(4'd14, d); chk("R9 zero write keeps", d, 64'h004);
        wr(4'd14, 64'h004);
        rd(4'd14, d); chk("R9 one write clears", d, 0);
        wr(4'd2, 64'hFFFF_FFFF_FFFF);
        wr(4'd10, c0(10'h004, 0, 0));
        pulse(16'h0001, 1);
        wr(4'd10, 0);
        rd(4'd2, d);  chk("R8 wrap value", d, 0);
        rd(4'd14, d); chk("R8 wrap no status", d, 0);
        wr(4'd6, 64'h8000_0000_0000);
        rd(4'd14, d); chk("R8 load no status", d, 0);
    endtask

    task automatic t_irq;
        logic [63:0] d;
        wr(4'd2, 64'h7FFF_FFFF_FFFF);
        wr(4'd10, c0(10'h004, 0, 0));
        pulse(16'h0001, 1);
        chk("R10 irq low mode off", irq_o, 0);
        wr(4'd10, c0(0, 10'h004, 3'd1));
        chk("R10 irq high", irq_o, 1);
        @(negedge clk);
        rd(4'd10, d); chk("R10 active flag set", d, c0(0, 10'h004, 3'd1) | 64'h800);
        wr(4'd10, c0(0, 0, 3'd1) | 64'h800);
        chk("R10 irq low without enable", irq_o, 0);
        @(negedge clk);
        rd(4'd10, d); chk("R11 write clears flag", d, c0(0, 0, 3'd1));
        wr(4'd10, c0(0, 10'h004, 3'd0));
        chk("R10 irq low mode off with enable", irq_o, 0);
        wr(4'd10, c0(0, 10'h004, 3'd1));
        chk("R10 irq high again", irq_o, 1);
        wr(4'd14, 64'h004);
        chk("R9 irq drops after clear", irq_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_map();
        t_fixed();
        t_select();
        t_hi_group();
        t_priv();
        t_write_wins();
        t_ovf();
        t_irq();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule